// File: doc/BRIEF.md
# Three-Phase Hall Commutation and Chopped Drive Core

This block is the digital core that turns rotor position into switch commands for a three-phase brushless motor bridge. Three Hall comparator bits are first resynchronised to the local clock. The block then decodes them into a role for each phase leg: sourcing (upper switch on), sinking (lower switch on) or floating (both off). The leg roles then pass through a per-leg state machine that drives two enables, one for the upper switch and one for the lower switch. That state machine never lets a leg change sides without a programmable number of dead clock cycles in between.

Drive strength is set by an external carrier comparison bit (`pwm_on`). This bit chops only the lower switch of the sinking leg. The upper switch of the sourcing leg stays fully on for the whole commutation step. A start/stop input selects between running and stopping. When stopped, a brake-select input chooses one of two behaviours. The first is coasting, with every switch open. The second is reverse-torque braking, where the decoded roles are swapped so that sourcing and sinking phases trade places. A shutdown input from protection logic forces every lower switch off.

Each leg state machine has five states. In `LEG_IDLE` both switches are off and there is no pending gap. In `LEG_SRC` the upper switch is on. In `LEG_SNK` the lower switch is on. `LEG_GAP_AFTER_SRC` and `LEG_GAP_AFTER_SNK` are timed blanking states entered when a switch turns off. The transitions are as follows:
- IDLE moves to SRC on an upper request, or to SNK on a lower request.
- SRC moves to GAP_AFTER_SRC when the upper request drops.
- SNK moves to GAP_AFTER_SNK when the lower request drops.
- A gap state returns at once to the switch it left if that request comes back. Otherwise it waits `DEAD_CYC` cycles. It then enters the opposite switch's state if that switch is requested, or IDLE if not.

Top module: `mdrv_commutator`

## Requirements
- R1: While running (`run_n`=0, `pwm_on`=1, `shutdown`=0), Hall codes written as (in1,in2,in3) map to leg roles (phase1,phase2,phase3) as follows:
  - 101 gives sink, source, float.
  - 100 gives sink, float, source.
  - 110 gives float, sink, source.
  - 010 gives source, sink, float.
  - 011 gives source, float, sink.
  - 001 gives float, source, sink.
  
  A source sets the leg's `hi_en` bit. A sink sets its `lo_en` bit. Bit i of `hall_raw`, `hi_en` and `lo_en` belongs to input/phase i+1.
- R2: Hall codes 000 and 111 turn all six enables off in every mode.
- R3: `pwm_on`=0 clears the sinking leg's `lo_en` one clock after it is sampled, and `pwm_on`=1 restores it one clock after. The sourcing leg's `hi_en` does not depend on `pwm_on`.
- R4: `run_n`=0 selects run. `run_n`=1 selects stop.
- R5: Stopped with `brk_sel`=1, all six enables are off.
- R6: Stopped with `brk_sel`=0, each leg takes the opposite role to the R1 mapping (source and sink swapped, float unchanged), and the sinking leg's lower switch is still gated by `pwm_on`.
- R7: `shutdown`=1 holds every `lo_en` bit at 0 and leaves the `hi_en` bits as the mode decides.
- R8: No leg ever has `hi_en` and `lo_en` high together.
- R9: After a switch of a leg turns off, the other switch of that leg stays off for at least `DEAD_CYC` clocks. When the other switch is requested at once, the gap is exactly `DEAD_CYC` clocks.
- R10: A change of `hall_raw` reaches the enables `SYNC_STAGES`+1 clocks after it is sampled.
- R11: During and directly after reset, all enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall_raw | input | 3 | Unsynchronised Hall comparator bits, bit i = sensor i+1 |
| pwm_on | input | 1 | Carrier comparison result, 1 = lower switch may conduct |
| run_n | input | 1 | 0 = run, 1 = stop |
| brk_sel | input | 1 | When stopped: 1 = coast, 0 = reverse-torque braking |
| shutdown | input | 1 | Protection request, forces lower switches off |
| hi_en | output | 3 | Upper switch enable per phase |
| lo_en | output | 3 | Lower switch enable per phase |

## Verification
The assertions check four things on every cycle:
- in each leg, a rising lower or upper enable is preceded by at least `DEAD_CYC` cycles with the opposite enable off;
- shutdown and a low carrier bit clear the lower enables on the next clock;
- coasting clears every enable on the next clock;
- the decoded roles always pair one source with one sink, or have neither.

Only the bench's scenarios can show the rest. These are the full commutation mapping across all eight Hall codes in the three modes with both carrier levels and both shutdown levels, the exact Hall latency, and that the dead gap equals `DEAD_CYC` rather than merely exceeding it.

// File: rtl/mdrv_pkg.sv
package mdrv_pkg;

    localparam int NPH = 3;

    typedef enum logic [1:0] {
        ROLE_FLOAT  = 2'd0,
        ROLE_SOURCE = 2'd1,
        ROLE_SINK   = 2'd2
    } role_t;

    typedef enum logic [1:0] {
        DRV_COAST = 2'd0,
        DRV_RUN   = 2'd1,
        DRV_BRAKE = 2'd2
    } drive_mode_t;

    typedef enum logic [2:0] {
        LEG_IDLE          = 3'd0,
        LEG_SRC           = 3'd1,
        LEG_SNK           = 3'd2,
        LEG_GAP_AFTER_SRC = 3'd3,
        LEG_GAP_AFTER_SNK = 3'd4
    } leg_state_t;

    function automatic role_t swap_role(input role_t r);
        unique case (r)
            ROLE_SOURCE: swap_role = ROLE_SINK;
            ROLE_SINK:   swap_role = ROLE_SOURCE;
            default:     swap_role = ROLE_FLOAT;
        endcase
    endfunction

endpackage

// File: rtl/mdrv_hall_sync.sv
module mdrv_hall_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= d_async;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/mdrv_role_decode.sv
module mdrv_role_decode
    import mdrv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPH-1:0]        hall,
    input  drive_mode_t           mode,
    output role_t [NPH-1:0]       role
);

    role_t [NPH-1:0] fwd;
    logic  [2:0]     code;

    // code written as (in1,in2,in3)
    assign code = {hall[0], hall[1], hall[2]};

    always_comb begin
        fwd = {ROLE_FLOAT, ROLE_FLOAT, ROLE_FLOAT};
        unique case (code)
            3'b101: begin
                fwd[0] = ROLE_SINK;
                fwd[1] = ROLE_SOURCE;
                fwd[2] = ROLE_FLOAT;
            end
            3'b100: begin
                fwd[0] = ROLE_SINK;
                fwd[1] = ROLE_FLOAT;
                fwd[2] = ROLE_SOURCE;
            end
            3'b110: begin
                fwd[0] = ROLE_FLOAT;
                fwd[1] = ROLE_SINK;
                fwd[2] = ROLE_SOURCE;
            end
            3'b010: begin
                fwd[0] = ROLE_SOURCE;
                fwd[1] = ROLE_SINK;
                fwd[2] = ROLE_FLOAT;
            end
            3'b011: begin
                fwd[0] = ROLE_SOURCE;
                fwd[1] = ROLE_FLOAT;
                fwd[2] = ROLE_SINK;
            end
            3'b001: begin
                fwd[0] = ROLE_FLOAT;
                fwd[1] = ROLE_SOURCE;
                fwd[2] = ROLE_SINK;
            end
            default: begin
                fwd = {ROLE_FLOAT, ROLE_FLOAT, ROLE_FLOAT};
            end
        endcase
    end

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        always_comb begin
            unique case (mode)
                DRV_RUN:   role[p] = fwd[p];
                DRV_BRAKE: role[p] = swap_role(fwd[p]);
                default:   role[p] = ROLE_FLOAT;
            endcase
        end
    end

    logic [NPH-1:0] src_mask;
    logic [NPH-1:0] snk_mask;
    for (genvar p = 0; p < NPH; p++) begin : g_mask
        assign src_mask[p] = (role[p] == ROLE_SOURCE);
        assign snk_mask[p] = (role[p] == ROLE_SINK);
    end

    AST_PAIRED_ROLES: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(src_mask) <= 1) && ($countones(src_mask) == $countones(snk_mask))); // R1

endmodule

// File: rtl/mdrv_leg_guard.sv
module mdrv_leg_guard
    import mdrv_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_hi,
    input  logic want_lo,
    output logic hi_en,
    output logic lo_en
);

    localparam int                CNT_W    = $clog2(DEAD_CYC + 1);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(DEAD_CYC - 1);
    localparam logic [CNT_W-1:0]  CNT_SAT  = CNT_W'(DEAD_CYC);

    leg_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LEG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LEG_IDLE: begin
                if (want_hi) begin
                    state_d = LEG_SRC;
                end else if (want_lo) begin
                    state_d = LEG_SNK;
                end
            end
            LEG_SRC: begin
                if (!want_hi) begin
                    state_d = LEG_GAP_AFTER_SRC;
                    cnt_d   = '0;
                end
            end
            LEG_SNK: begin
                if (!want_lo) begin
                    state_d = LEG_GAP_AFTER_SNK;
                    cnt_d   = '0;
                end
            end
            LEG_GAP_AFTER_SRC: begin
                if (want_hi) begin
                    state_d = LEG_SRC;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = want_lo ? LEG_SNK : LEG_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            LEG_GAP_AFTER_SNK: begin
                if (want_lo) begin
                    state_d = LEG_SNK;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = want_hi ? LEG_SRC : LEG_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = LEG_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            LEG_SRC: begin
                hi_en = 1'b1;
                lo_en = 1'b0;
            end
            LEG_SNK: begin
                hi_en = 1'b0;
                lo_en = 1'b1;
            end
            default: begin
                hi_en = 1'b0;
                lo_en = 1'b0;
            end
        endcase
    end

    // Independent off-time trackers used only by the checks below
    logic [CNT_W-1:0] hi_off_age, lo_off_age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_off_age <= CNT_SAT;
            lo_off_age <= CNT_SAT;
        end else begin
            if (hi_en) begin
                hi_off_age <= '0;
            end else if (hi_off_age != CNT_SAT) begin
                hi_off_age <= hi_off_age + 1'b1;
            end
            if (lo_en) begin
                lo_off_age <= '0;
            end else if (lo_off_age != CNT_SAT) begin
                lo_off_age <= lo_off_age + 1'b1;
            end
        end
    end

    AST_GAP_UPPER_TO_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_en) |-> (hi_off_age >= CNT_SAT) && !hi_en); // R8 R9

    AST_GAP_LOWER_TO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_en) |-> (lo_off_age >= CNT_SAT) && !lo_en); // R8 R9

endmodule

// File: rtl/mdrv_commutator.sv
module mdrv_commutator
    import mdrv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEAD_CYC    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_raw,
    input  logic       pwm_on,
    input  logic       run_n,
    input  logic       brk_sel,
    input  logic       shutdown,
    output logic [2:0] hi_en,
    output logic [2:0] lo_en
);

    logic [NPH-1:0]  hall_s;
    drive_mode_t     mode;
    role_t [NPH-1:0] role;
    logic [NPH-1:0]  want_hi;
    logic [NPH-1:0]  want_lo;

    mdrv_hall_sync #(
        .WIDTH  (NPH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (hall_raw),
        .q_sync  (hall_s)
    );

    always_comb begin
        if (!run_n) begin
            mode = DRV_RUN;
        end else if (brk_sel) begin
            mode = DRV_COAST;
        end else begin
            mode = DRV_BRAKE;
        end
    end

    mdrv_role_decode u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .hall  (hall_s),
        .mode  (mode),
        .role  (role)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_leg
        assign want_hi[p] = (role[p] == ROLE_SOURCE);
        assign want_lo[p] = (role[p] == ROLE_SINK) && pwm_on && !shutdown;

        mdrv_leg_guard #(
            .DEAD_CYC (DEAD_CYC)
        ) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .want_hi (want_hi[p]),
            .want_lo (want_lo[p]),
            .hi_en   (hi_en[p]),
            .lo_en   (lo_en[p])
        );
    end

    AST_SHUTDOWN_LOWER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (lo_en == 3'b000)); // R7

    AST_CARRIER_GATES_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_on |=> (lo_en == 3'b000)); // R3

    AST_COAST_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (run_n && brk_sel) |=> (hi_en == 3'b000) && (lo_en == 3'b000)); // R5

endmodule

// File: tb/tb_mdrv_commutator.sv
`timescale 1ns/1ps
module tb_mdrv_commutator;

    localparam int SYNC = 2;
    localparam int DEAD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_raw = 3'b000;
    logic       pwm_on = 1'b1;
    logic       run_n = 1'b1;
    logic       brk_sel = 1'b1;
    logic       shutdown = 1'b0;
    logic [2:0] hi_en, lo_en;

    int n_chk = 0;
    int n_fail = 0;
    int viol = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mdrv_commutator #(
        .SYNC_STAGES (SYNC),
        .DEAD_CYC    (DEAD)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .hall_raw (hall_raw),
        .pwm_on   (pwm_on),
        .run_n    (run_n),
        .brk_sel  (brk_sel),
        .shutdown (shutdown),
        .hi_en    (hi_en),
        .lo_en    (lo_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // 0 float, 1 source, 2 sink; hall bit i = sensor i+1
    function automatic int fwd_role(input logic [2:0] h, input int p);
        logic [2:0] c;
        int r [3];
        c = {h[0], h[1], h[2]};
        case (c)
            3'b101: r = '{2, 1, 0};
            3'b100: r = '{2, 0, 1};
            3'b110: r = '{0, 2, 1};
            3'b010: r = '{1, 2, 0};
            3'b011: r = '{1, 0, 2};
            3'b001: r = '{0, 1, 2};
            default: r = '{0, 0, 0};
        endcase
        return r[p];
    endfunction

    // mode: 0 run, 1 coast, 2 brake
    function automatic logic [5:0] expect_out(input int mode, input logic [2:0] h,
                                              input logic pwm, input logic sd);
        logic [2:0] eh, el;
        eh = '0;
        el = '0;
        for (int p = 0; p < 3; p++) begin
            int r;
            r = fwd_role(h, p);
            if (mode == 1) r = 0;
            else if (mode == 2) r = (r == 1) ? 2 : (r == 2) ? 1 : 0;
            eh[p] = (r == 1);
            el[p] = (r == 2) && pwm && !sd;
        end
        return {eh, el};
    endfunction

    // Dead-time monitor on the ports
    int hage [3] = '{100, 100, 100};
    int lage [3] = '{100, 100, 100};
    logic [2:0] phi = '0, plo = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < 3; p++) begin
                if (hi_en[p] && lo_en[p]) viol++;
                if (lo_en[p] && !plo[p] && hage[p] < DEAD) viol++;
                if (hi_en[p] && !phi[p] && lage[p] < DEAD) viol++;
                hage[p] = hi_en[p] ? 0 : (hage[p] < 100 ? hage[p] + 1 : hage[p]);
                lage[p] = lo_en[p] ? 0 : (lage[p] < 100 ? lage[p] + 1 : lage[p]);
            end
            phi = hi_en;
            plo = lo_en;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int k;
        int gap;
        repeat (3) @(negedge clk);
        chk("R11 in reset", {hi_en, lo_en}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after reset", {hi_en, lo_en}, 6'b0);

        // R4: run vs stop with coast select
        hall_raw = 3'b010;
        run_n = 1'b0;
        repeat (20) @(negedge clk);
        chk("R4 run active", {hi_en, lo_en}, expect_out(0, 3'b010, 1'b1, 1'b0));
        run_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R4 stop idle", {hi_en, lo_en}, 6'b0);

        // Sweep every mode, Hall code, carrier and shutdown level
        for (int m = 0; m < 3; m++) begin
            for (int h = 0; h < 8; h++) begin
                for (int pw = 0; pw < 2; pw++) begin
                    for (int sd = 0; sd < 2; sd++) begin
                        string tag;
                        run_n    = (m != 0);
                        brk_sel  = (m == 1);
                        hall_raw = 3'(h);
                        pwm_on   = pw[0];
                        shutdown = sd[0];
                        repeat (20) @(negedge clk);
                        if (h == 0 || h == 7) tag = "R2 invalid code";
                        else if (m == 1) tag = "R5 coast";
                        else if (m == 2) tag = "R6 brake";
                        else if (sd != 0) tag = "R7 shutdown";
                        else if (pw == 0) tag = "R3 carrier low";
                        else tag = "R1 commutation";
                        chk(tag, {hi_en, lo_en},
                            expect_out(m, 3'(h), pw[0], sd[0]));
                    end
                end
            end
        end

        // R10 and R9: latency and exact gap, phase 1 source -> sink
        run_n = 1'b0; brk_sel = 1'b1; pwm_on = 1'b1; shutdown = 1'b0;
        hall_raw = 3'b010;
        repeat (20) @(negedge clk);
        hall_raw = 3'b101;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (hi_en[0] && k < 30);
        chk("R10 hall latency", k, SYNC + 1);
        gap = 0;
        while (!lo_en[0] && gap < 50) begin
            gap++;
            @(negedge clk);
        end
        chk("R9 gap src->snk", gap, DEAD);

        // R9 sink -> source
        hall_raw = 3'b010;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (lo_en[0] && k < 30);
        chk("R10 hall latency back", k, SYNC + 1);
        gap = 0;
        while (!hi_en[0] && gap < 50) begin
            gap++;
            @(negedge clk);
        end
        chk("R9 gap snk->src", gap, DEAD);

        // R3: one-clock carrier response, source unaffected
        hall_raw = 3'b101;
        repeat (20) @(negedge clk);
        pwm_on = 1'b0;
        @(negedge clk);
        chk("R3 lower off next clock", lo_en[0], 1'b0);
        chk("R3 upper kept", hi_en, 3'b010);
        pwm_on = 1'b1;
        @(negedge clk);
        chk("R3 lower back next clock", lo_en[0], 1'b1);

        // R6: sinking leg in brake still follows carrier
        run_n = 1'b1; brk_sel = 1'b0;
        repeat (20) @(negedge clk);
        chk("R6 brake roles", {hi_en, lo_en}, expect_out(2, 3'b101, 1'b1, 1'b0));

        repeat (5) @(negedge clk);
        chk("R8 R9 monitor violations", viol, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule